// File: doc/BRIEF.md
# Synthesizer Configuration Port with Serial and Parallel Loading

This block keeps the setup word of a PLL clock synthesizer. The word has three fields: a 9-bit feedback divider value, a 2-bit post-divide select and a 3-bit test-node select. Two independent paths can write the word into one shared set of configuration latches.

The serial path is a three-wire port with a shift clock, a data line and a load strobe. A 14-bit shift register takes one data bit on each rising shift clock edge. The register contents move into the latches when the load strobe falls. The parallel path copies the divider value and the post-divide select from input pins when its own strobe rises. It never writes the test-node select.

All port inputs are brought into the system clock domain through a two-stage synchronizer, and edges are found there. A two-state machine arbitrates between the paths:

- `ST_IDLE`: the parallel strobe is low. The transition `ST_IDLE -> ST_PAR_FOLLOW` is taken on a rising parallel strobe. If a serial load falls in the same cycle, the parallel capture wins.
- `ST_PAR_FOLLOW`: the parallel strobe is held high. The latches track the pins and serial loads are dropped. The transition `ST_PAR_FOLLOW -> ST_IDLE` is taken when the synchronized strobe reads low.

Top module: `synth_cfg_port`

## Requirements
- R1: After reset the outputs are divider 0, post-divide select 00 and test select 000, and `div_sel` reads 0001. The shift register also clears to zero, so a word made of only three shifted ones loads as divider 7 with the other fields 0.
- R2: The shift register is 14 bits long. It shifts left by one on each rising edge of `ser_clk` and takes `ser_dat` into bit 0. Bits [13:11] are the test select, bits [10:9] the post-divide select and bits [8:0] the divider. Sending the word MSB first leaves divider bit 0 in bit 0.
- R3: The serial word reaches the latches only on a falling edge of `ser_ld`. A rising edge of `ser_ld` leaves the outputs unchanged.
- R4: A rising edge of `par_ld` in `ST_IDLE` loads `par_m` into the divider and `par_n` into the post-divide select. The test select keeps its value.
- R5: When a rising `par_ld` and a falling `ser_ld` fall in the same cycle, the parallel values are loaded. The whole serial word, including its test select, is discarded.
- R6: While `par_ld` is held high, the divider and post-divide outputs follow the pins. A serial load in that time changes nothing, and the test select keeps its value.
- R7: `div_sel` is one-hot: bit k is set when the post-divide select equals k. The codes 00, 01, 10 and 11 mean ratios 1, 2, 4 and 8.
- R8: While `par_ld` stays low, changes on `par_m` and `par_n` do not reach the outputs.
- R9: When more than 14 shift clocks come before a load, only the last 14 bits sent are kept.
- R10: An output changes on the third rising `clk` edge after the strobe edge that causes it. Every level on the port inputs must be held for at least three `clk` periods.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ser_clk | input | 1 | Serial shift clock |
| ser_dat | input | 1 | Serial data bit |
| ser_ld | input | 1 | Serial load strobe, acts on its falling edge |
| par_ld | input | 1 | Parallel load strobe, acts on its rising edge and while held high |
| par_m | input | 9 | Parallel divider value |
| par_n | input | 2 | Parallel post-divide select |
| cfg_m | output | 9 | Latched feedback divider value |
| cfg_n | output | 2 | Latched post-divide select |
| cfg_t | output | 3 | Latched test-node select |
| div_sel | output | 4 | One-hot post-divide ratio (bit0 = 1, bit3 = 8) |

## Verification
The bench goes after the collision of a parallel rising edge with a serial falling edge. A design that let the serial path win there would bring in the serial test select. It also checks that a serial load sent while the parallel strobe is held high is dropped, and that a rising serial strobe does nothing; a design that got either wrong would overwrite the latches too early. An overlong serial stream and a three-bit stream sent right after reset show whether the shift register truly holds 14 bits and truly clears. A wrong length or a missing clear would change the high fields. The exact output latency is sampled one cycle before and at the update, so an extra or a missing synchronizer stage shows up.

// File: rtl/synth_cfg_pkg.sv
package synth_cfg_pkg;
    localparam int M_W    = 9;
    localparam int N_W    = 2;
    localparam int T_W    = 3;
    localparam int WORD_W = M_W + N_W + T_W;
    localparam int SEL_W  = 1 << N_W;

    typedef struct packed {
        logic [T_W-1:0] t;
        logic [N_W-1:0] n;
        logic [M_W-1:0] m;
    } cfg_word_t;

    typedef enum logic {
        ST_IDLE       = 1'b0,
        ST_PAR_FOLLOW = 1'b1
    } ld_state_e;
endpackage

// File: rtl/cfg_sync.sv
module cfg_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] pipe [STAGES];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) pipe[i] <= '0;
        end else begin
            pipe[0] <= d;
            for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
        end
    end

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/cfg_edge.sv
module cfg_edge #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lvl,
    output logic [W-1:0] rise,
    output logic [W-1:0] fall
);
    logic [W-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= lvl;
    end

    for (genvar g = 0; g < W; g++) begin : g_edge
        assign rise[g] =  lvl[g] & ~prev_q[g];
        assign fall[g] = ~lvl[g] &  prev_q[g];
    end
endmodule

// File: rtl/cfg_shift.sv
module cfg_shift #(
    parameter int W = 14
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         shift_en,
    input  logic         din,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (!rst_n)        q <= '0;
        else if (shift_en) q <= {q[W-2:0], din};
    end

    AST_SHIFT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_en |=> $stable(q)); // R2
    AST_SHIFT_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en |=> q[W-1:1] == $past(q[W-2:0])); // R2
endmodule

// File: rtl/synth_cfg_port.sv
module synth_cfg_port
    import synth_cfg_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ser_clk,
    input  logic             ser_dat,
    input  logic             ser_ld,
    input  logic             par_ld,
    input  logic [M_W-1:0]   par_m,
    input  logic [N_W-1:0]   par_n,
    output logic [M_W-1:0]   cfg_m,
    output logic [N_W-1:0]   cfg_n,
    output logic [T_W-1:0]   cfg_t,
    output logic [SEL_W-1:0] div_sel
);
    localparam int CTL_W = 4;
    localparam int PIN_W = M_W + N_W;

    logic [CTL_W-1:0] ctl_s;
    logic [PIN_W-1:0] pin_s;
    logic [M_W-1:0]   pin_m_s;
    logic [N_W-1:0]   pin_n_s;
    logic [2:0]       stb_rise, stb_fall;
    logic             sclk_rise, sld_fall, pld_rise, pld_lvl;
    logic [WORD_W-1:0] sreg;
    cfg_word_t        cfg_q;
    ld_state_e        state_q, state_d;

    cfg_sync #(.W(CTL_W), .STAGES(SYNC_STAGES)) u_ctl_sync (
        .clk(clk), .rst_n(rst_n),
        .d({par_ld, ser_ld, ser_dat, ser_clk}), .q(ctl_s));

    cfg_sync #(.W(PIN_W), .STAGES(SYNC_STAGES)) u_pin_sync (
        .clk(clk), .rst_n(rst_n), .d({par_m, par_n}), .q(pin_s));

    assign pin_m_s = pin_s[PIN_W-1:N_W];
    assign pin_n_s = pin_s[N_W-1:0];

    cfg_edge #(.W(3)) u_edge (
        .clk(clk), .rst_n(rst_n),
        .lvl({ctl_s[3], ctl_s[2], ctl_s[0]}),
        .rise(stb_rise), .fall(stb_fall));

    assign sclk_rise = stb_rise[0];
    assign sld_fall  = stb_fall[1];
    assign pld_rise  = stb_rise[2];
    assign pld_lvl   = ctl_s[3];

    cfg_shift #(.W(WORD_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .shift_en(sclk_rise),
        .din(ctl_s[1]), .q(sreg));

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:       if (pld_rise) state_d = ST_PAR_FOLLOW;
            ST_PAR_FOLLOW: if (!pld_lvl) state_d = ST_IDLE;
            default:       state_d = ST_IDLE;
        endcase
    end

    // configuration latches: parallel checked first, so it wins
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (pld_rise) begin
                        cfg_q.m <= pin_m_s;
                        cfg_q.n <= pin_n_s;
                    end else if (sld_fall) begin
                        cfg_q <= cfg_word_t'(sreg);
                    end
                end
                ST_PAR_FOLLOW: begin
                    cfg_q.m <= pin_m_s;
                    cfg_q.n <= pin_n_s;
                end
                default: cfg_q <= cfg_q;
            endcase
        end
    end

    assign cfg_m = cfg_q.m;
    assign cfg_n = cfg_q.n;
    assign cfg_t = cfg_q.t;

    for (genvar k = 0; k < SEL_W; k++) begin : g_sel
        assign div_sel[k] = (cfg_q.n == N_W'(k));
    end

    AST_QUIET_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !pld_rise && !sld_fall) |=> $stable(cfg_q)); // R3
    AST_PAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && pld_rise) |=>
            (cfg_q.m == $past(pin_m_s) && cfg_q.n == $past(pin_n_s) && $stable(cfg_q.t))); // R5
    AST_FOLLOW_PINS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PAR_FOLLOW) |=> (cfg_q.m == $past(pin_m_s) && $stable(cfg_q.t))); // R6
    AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot(div_sel)); // R7
endmodule

// File: tb/synth_cfg_port_tb.sv
module synth_cfg_port_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ser_clk = 1'b0, ser_dat = 1'b0, ser_ld = 1'b0, par_ld = 1'b0;
    logic [8:0] par_m = '0;
    logic [1:0] par_n = '0;
    logic [8:0] cfg_m;
    logic [1:0] cfg_n;
    logic [2:0] cfg_t;
    logic [3:0] div_sel;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #10 clk = ~clk;

    synth_cfg_port dut_i (
        .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_dat(ser_dat),
        .ser_ld(ser_ld), .par_ld(par_ld), .par_m(par_m), .par_n(par_n),
        .cfg_m(cfg_m), .cfg_n(cfg_n), .cfg_t(cfg_t), .div_sel(div_sel));

    // fields: T[13:11] N[10:9] M[8:0]
    localparam logic [13:0] VEC [6] = '{
        14'b000_00_000000001, 14'b101_01_110011001, 14'b111_11_111111111,
        14'b010_10_100000000, 14'b001_11_010101010, 14'b110_00_001111000};

    task automatic chk(string tag, int got, int exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
        end
    endtask

    task automatic wait_n(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic ser_bit(logic b);
        ser_dat = b; wait_n(4);
        ser_clk = 1'b1; wait_n(4);
        ser_clk = 1'b0; wait_n(4);
    endtask

    task automatic ser_word(logic [15:0] w, int len);
        for (int i = len - 1; i >= 0; i--) ser_bit(w[i]);
    endtask

    task automatic ser_load();
        ser_ld = 1'b1; wait_n(5);
        ser_ld = 1'b0; wait_n(6);
    endtask

    task automatic chk_word(string tag, logic [13:0] w);
        chk({tag, " m"}, int'(cfg_m), int'(w[8:0]));
        chk({tag, " n"}, int'(cfg_n), int'(w[10:9]));
        chk({tag, " t"}, int'(cfg_t), int'(w[13:11]));
    endtask

    initial begin
        wait_n(5);
        rst_n = 1'b1;
        wait_n(2);
        // R1 reset values
        chk("R1 reset m", int'(cfg_m), 0);
        chk("R1 reset n", int'(cfg_n), 0);
        chk("R1 reset t", int'(cfg_t), 0);
        chk("R1 reset div_sel", int'(div_sel), 1);
        // R1 shift register cleared: three ones only
        ser_word(16'h0007, 3); ser_load();
        chk_word("R1 cleared sreg", 14'h0007);

        // R2 R7 vector table
        for (int v = 0; v < 6; v++) begin
            ser_word({2'b00, VEC[v]}, 14); ser_load();
            chk_word("R2 vector", VEC[v]);
            chk("R7 div_sel", int'(div_sel), int'(4'b0001 << VEC[v][10:9]));
        end

        // R9 overlong stream: two leading bits must drop off
        ser_word({2'b11, 14'b000_10_000000011}, 16); ser_load();
        chk_word("R9 overlong", 14'b000_10_000000011);

        // R3 rising ser_ld alone does nothing; R10 latency on falling edge
        ser_word({2'b00, 14'b011_01_000011110}, 14);
        ser_ld = 1'b1; wait_n(6);
        chk("R3 rise ignored", int'(cfg_m), 9'b000000011);
        ser_ld = 1'b0; wait_n(2);
        chk("R10 before update", int'(cfg_m), 9'b000000011);
        wait_n(1);
        chk("R10 at update", int'(cfg_m), 9'b000011110);
        chk("R3 fall loads t", int'(cfg_t), 3'b011);
        wait_n(4);

        // R4 parallel capture keeps T
        par_m = 9'h1A5; par_n = 2'd2; wait_n(4);
        par_ld = 1'b1; wait_n(5);
        chk("R4 par m", int'(cfg_m), 9'h1A5);
        chk("R4 par n", int'(cfg_n), 2);
        chk("R4 t kept", int'(cfg_t), 3'b011);
        // R6 follow pins, serial ignored while held
        par_m = 9'h03C; par_n = 2'd3; wait_n(5);
        chk("R6 follow m", int'(cfg_m), 9'h03C);
        chk("R6 follow n", int'(cfg_n), 3);
        ser_word({2'b00, 14'b100_00_101010101}, 14); ser_load();
        chk("R6 serial ignored m", int'(cfg_m), 9'h03C);
        chk("R6 serial ignored t", int'(cfg_t), 3'b011);
        par_ld = 1'b0; wait_n(5);

        // R8 pins ignored while strobe low
        par_m = 9'h0F0; par_n = 2'd1; wait_n(8);
        chk("R8 pins ignored m", int'(cfg_m), 9'h03C);
        chk("R8 pins ignored n", int'(cfg_n), 3);

        // R5 simultaneous: parallel wins, serial T discarded
        ser_word({2'b00, 14'b111_00_000000101}, 14);
        ser_ld = 1'b1; wait_n(5);
        ser_ld = 1'b0; par_ld = 1'b1; wait_n(6);
        chk("R5 par wins m", int'(cfg_m), 9'h0F0);
        chk("R5 par wins n", int'(cfg_n), 1);
        chk("R5 serial t dropped", int'(cfg_t), 3'b011);
        par_ld = 1'b0; wait_n(5);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog got=hung exp=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule